// File: doc/BRIEF.md
# Prioritized Interrupt Vector Sequencer

This block is the interrupt-entry and interrupt-return controller of a small 16-bit multi-cycle processor core. It watches fourteen level-sensitive maskable request lines, one non-maskable request and one reset request. At each instruction boundary it picks the most urgent pending source. It then runs a fixed sequence of memory and register steps that saves the return context on a downward-growing stack and loads the program counter from that source's vector word at the top of memory.

The core keeps its PC, status and stack-pointer registers and shows them to the block. The block changes them only through load strobes. The core stalls while `busy` is high. Memory is a single-port word memory: a read issued in one cycle returns its data on `mem_rdata` in the next cycle. When the core executes its return-from-interrupt instruction, it raises `ret_req`. The block then restores the status register and the PC from the stack in a fixed number of cycles.

Top module: `irq_vector_seq`

## Requirements
- R1: When several sources are pending at a decision point, the highest-numbered one is serviced. Reset is 15, the non-maskable source is 14, and maskable line k is source k (0 to 13).
- R2: Source n is serviced by a memory read at address 0xFFE0 + 2n. In that same cycle `ack` is high and `ack_id` equals n.
- R3: Maskable lines start an entry only when `insn_done` is high and status bit 3 (global enable) is set. While bit 3 is clear they have no effect on the PC or on `busy`. The non-maskable and reset sources ignore bit 3.
- R4: Entry writes the PC to address SP-2, then writes the status register to SP-4 in the next cycle. It then loads the status register with 0 and the stack pointer with SP-4.
- R5: An entry keeps `busy` high for exactly 6 cycles and loads the PC with the vector word read in R2.
- R6: A return started by `ret_req` loads the status register from the word at SP and the PC from the word at SP+2, then loads SP+4. `busy` is high for exactly 5 cycles.
- R7: A rising edge on `rst_req` aborts any sequence in progress and suppresses its remaining steps. It writes no stack word and does not touch SP. It clears the status register and loads the PC from 0xFFFE, with `busy` high for 2 cycles when started from idle.
- R8: `ack` is a single-cycle pulse, given once for each serviced source.
- R9: A rising edge on the non-maskable request is latched and held until that source is serviced, even when it arrives during a sequence. Maskable lines are levels and are re-evaluated at the next boundary after a sequence.
- R10: When `ret_req` and a serviceable interrupt meet at the same boundary, the return runs first and gives no acknowledge.
- R11: While and after `rst_n` is low, the block is idle with no memory request, no acknowledge and no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 14 | Maskable request levels, bit k is source k |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| rst_req | input | 1 | Reset request, rising-edge sensitive |
| insn_done | input | 1 | Current instruction completes this cycle |
| ret_req | input | 1 | Core is executing the return-from-interrupt |
| pc_in | input | 16 | Address of the next instruction |
| sr_in | input | 16 | Current status register, bit 3 is global enable |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | A sequence is in progress; core stalls |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| pc_ld | output | 1 | Load PC with pc_nxt |
| pc_nxt | output | 16 | New PC value |
| sr_ld | output | 1 | Load status register with sr_nxt |
| sr_nxt | output | 16 | New status value |
| sp_ld | output | 1 | Load stack pointer with sp_nxt |
| sp_nxt | output | 16 | New stack pointer value |
| ack | output | 1 | Vector fetch pulse for the serviced source |
| ack_id | output | 4 | Index of the serviced source |

## Verification
Two situations can land in the same cycle. First, the return request can coincide with a pending, enabled interrupt at one boundary. The bench raises both together and expects a 5-cycle return with no acknowledge and a restored PC, followed by the interrupt's entry at the next boundary. Second, a reset edge can arrive while an entry is under way, or together with a non-maskable edge. The bench injects it one cycle into an entry and expects no further stack write, an unchanged SP and a PC from 0xFFFE. When the reset and non-maskable edges are raised together, it expects reset first and then the held non-maskable request.

// File: rtl/irq_seq_pkg.sv
// Package: shared state encoding for the interrupt vector sequencer.
// Assumes: one state register in the sequencer; order of the entry,
// return and reset groups is not decoded elsewhere.
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_E1,   // push return PC
        ST_E2,   // push status
        ST_E3,   // clear status, commit stack pointer
        ST_E4,   // vector read, acknowledge
        ST_E5,   // load PC from vector word
        ST_E6,   // settle, first handler instruction follows
        ST_R1,   // read saved status
        ST_R2,   // restore status, read saved PC
        ST_R3,   // restore PC, commit stack pointer
        ST_R4,   // settle
        ST_R5,   // settle
        ST_X1,   // reset vector read, clear status
        ST_X2    // load PC from reset vector
    } seq_state_t;

endpackage

// File: rtl/irq_edge_latch.sv
// Module: irq_edge_latch
// Turns rising edges of request inputs into sticky pending bits.
// A pending bit stays set until its clear strobe; a new edge in the
// same cycle as a clear wins, so no edge is lost.
module irq_edge_latch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_in,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    logic [W-1:0] req_q;
    logic [W-1:0] rise;

    // Edge detect against the previous sample.
    assign rise = req_in & ~req_q;

    // Sample inputs and update sticky pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req_in;
            pend  <= (pend & ~clr) | rise;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority selector: the highest set index of the pending vector
// wins. Purely combinational; valid is low when nothing is pending.
module irq_prio_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          valid,
    output logic [IW-1:0] id
);

    // Scan upward so later (higher) indices override earlier ones.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                valid = 1'b1;
                id    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
// Module: irq_seq_fsm
// Entry, return and reset sequencer. Decides at each boundary, then
// walks a fixed-length state chain driving memory and register loads.
// Assumes: core holds pc_in/sr_in/sp_in except through our strobes,
// memory read data arrives one cycle after the request.
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int          W        = 16,
    parameter int          N_SRC    = 16,
    parameter int          IW       = $clog2(N_SRC),
    parameter int          GIE_BIT  = 3,
    parameter logic [W-1:0] VEC_BASE = 16'hFFE0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_pend,
    input  logic          sel_valid,
    input  logic [IW-1:0] sel_id,
    input  logic          insn_done,
    input  logic          ret_req,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  sr_in,
    input  logic [W-1:0]  sp_in,
    input  logic [W-1:0]  mem_rdata,
    output logic          gie,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          pc_ld,
    output logic [W-1:0]  pc_nxt,
    output logic          sr_ld,
    output logic [W-1:0]  sr_nxt,
    output logic          sp_ld,
    output logic [W-1:0]  sp_nxt,
    output logic          ack,
    output logic [IW-1:0] ack_id
);

    localparam logic [IW-1:0] ID_RST   = IW'(N_SRC - 1);
    localparam logic [W-1:0]  WORD_B   = W'(2);
    localparam logic [W-1:0]  FRAME_B  = W'(4);

    seq_state_t    st, st_d;
    logic [IW-1:0] src_q, src_d;
    logic          abort;

    // Vector word address of a source index.
    function automatic logic [W-1:0] vec_of(input logic [IW-1:0] id);
        return VEC_BASE + (W'(id) << 1);
    endfunction

    assign gie   = sr_in[GIE_BIT];
    assign busy  = (st != ST_IDLE);
    // A pending reset squashes whatever step is in flight.
    assign abort = rst_pend && (st != ST_X1);

    // Next-state and source-latch decision.
    always_comb begin
        st_d  = st;
        src_d = src_q;
        if (abort) begin
            st_d = ST_X1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ret_req) begin
                        st_d = ST_R1;
                    end else if (insn_done && sel_valid) begin
                        st_d  = ST_E1;
                        src_d = sel_id;
                    end
                end
                ST_E1:   st_d = ST_E2;
                ST_E2:   st_d = ST_E3;
                ST_E3:   st_d = ST_E4;
                ST_E4:   st_d = ST_E5;
                ST_E5:   st_d = ST_E6;
                ST_E6:   st_d = ST_IDLE;
                ST_R1:   st_d = ST_R2;
                ST_R2:   st_d = ST_R3;
                ST_R3:   st_d = ST_R4;
                ST_R4:   st_d = ST_R5;
                ST_R5:   st_d = ST_IDLE;
                ST_X1:   st_d = ST_X2;
                ST_X2:   st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State and serviced-source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            src_q <= '0;
        end else begin
            st    <= st_d;
            src_q <= src_d;
        end
    end

    // Per-state memory and register-load outputs.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_ld     = 1'b0;
        pc_nxt    = '0;
        sr_ld     = 1'b0;
        sr_nxt    = '0;
        sp_ld     = 1'b0;
        sp_nxt    = '0;
        ack       = 1'b0;
        ack_id    = '0;
        if (!abort) begin
            case (st)
                ST_E1: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = sp_in - WORD_B;
                    mem_wdata = pc_in;
                end
                ST_E2: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = sp_in - FRAME_B;
                    mem_wdata = sr_in;
                end
                ST_E3: begin
                    sr_ld  = 1'b1;
                    sp_ld  = 1'b1;
                    sp_nxt = sp_in - FRAME_B;
                end
                ST_E4: begin
                    mem_req  = 1'b1;
                    mem_addr = vec_of(src_q);
                    ack      = 1'b1;
                    ack_id   = src_q;
                end
                ST_E5: begin
                    pc_ld  = 1'b1;
                    pc_nxt = mem_rdata;
                end
                ST_R1: begin
                    mem_req  = 1'b1;
                    mem_addr = sp_in;
                end
                ST_R2: begin
                    sr_ld    = 1'b1;
                    sr_nxt   = mem_rdata;
                    mem_req  = 1'b1;
                    mem_addr = sp_in + WORD_B;
                end
                ST_R3: begin
                    pc_ld  = 1'b1;
                    pc_nxt = mem_rdata;
                    sp_ld  = 1'b1;
                    sp_nxt = sp_in + FRAME_B;
                end
                ST_X1: begin
                    mem_req  = 1'b1;
                    mem_addr = vec_of(ID_RST);
                    sr_ld    = 1'b1;
                    ack      = 1'b1;
                    ack_id   = ID_RST;
                end
                ST_X2: begin
                    pc_ld  = 1'b1;
                    pc_nxt = mem_rdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_seq.sv
// Module: irq_vector_seq (top)
// Interrupt entry/return sequencer for a 16-bit multi-cycle core.
// Latches edge-type sources, masks level sources with the global
// enable, picks the highest pending index and runs the sequencer.
// Assumes: core stalls while busy; read data one cycle after request.
module irq_vector_seq #(
    parameter int           W        = 16,
    parameter int           N_SRC    = 16,
    parameter int           GIE_BIT  = 3,
    parameter logic [W-1:0] VEC_BASE = 16'hFFE0,
    localparam int          N_MASK   = N_SRC - 2,
    localparam int          IW       = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MASK-1:0] irq_lines,
    input  logic              nmi_req,
    input  logic              rst_req,
    input  logic              insn_done,
    input  logic              ret_req,
    input  logic [W-1:0]      pc_in,
    input  logic [W-1:0]      sr_in,
    input  logic [W-1:0]      sp_in,
    input  logic [W-1:0]      mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    output logic              pc_ld,
    output logic [W-1:0]      pc_nxt,
    output logic              sr_ld,
    output logic [W-1:0]      sr_nxt,
    output logic              sp_ld,
    output logic [W-1:0]      sp_nxt,
    output logic              ack,
    output logic [IW-1:0]     ack_id
);

    localparam logic [IW-1:0] ID_NMI = IW'(N_SRC - 2);
    localparam logic [IW-1:0] ID_RST = IW'(N_SRC - 1);

    logic [1:0]       edge_pend;   // [1] reset, [0] non-maskable
    logic [1:0]       edge_clr;
    logic             gie;
    logic [N_SRC-1:0] pend_vec;
    logic             sel_valid;
    logic [IW-1:0]    sel_id;

    // Clear a sticky edge source when its vector is fetched.
    assign edge_clr[1] = ack && (ack_id == ID_RST);
    assign edge_clr[0] = ack && (ack_id == ID_NMI);

    // Pending vector in priority order, maskable part gated by enable.
    assign pend_vec = {edge_pend[1], edge_pend[0], irq_lines & {N_MASK{gie}}};

    irq_edge_latch #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in ({rst_req, nmi_req}),
        .clr    (edge_clr),
        .pend   (edge_pend)
    );

    irq_prio_pick #(.N(N_SRC), .IW(IW)) u_pick (
        .pend  (pend_vec),
        .valid (sel_valid),
        .id    (sel_id)
    );

    irq_seq_fsm #(
        .W        (W),
        .N_SRC    (N_SRC),
        .IW       (IW),
        .GIE_BIT  (GIE_BIT),
        .VEC_BASE (VEC_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_pend  (edge_pend[1]),
        .sel_valid (sel_valid),
        .sel_id    (sel_id),
        .insn_done (insn_done),
        .ret_req   (ret_req),
        .pc_in     (pc_in),
        .sr_in     (sr_in),
        .sp_in     (sp_in),
        .mem_rdata (mem_rdata),
        .gie       (gie),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_ld     (pc_ld),
        .pc_nxt    (pc_nxt),
        .sr_ld     (sr_ld),
        .sr_nxt    (sr_nxt),
        .sp_ld     (sp_ld),
        .sp_nxt    (sp_nxt),
        .ack       (ack),
        .ack_id    (ack_id)
    );

endmodule

// File: rtl/irq_vector_seq_chk.sv
// Module: irq_vector_seq_chk
// Property checker bound to irq_vector_seq. Watches the port-level
// behaviour only; the busy-run length is tracked by a local counter.
module irq_vector_seq_chk #(
    parameter int           W        = 16,
    parameter int           N_SRC    = 16,
    parameter logic [W-1:0] VEC_BASE = 16'hFFE0,
    localparam int          IW       = $clog2(N_SRC)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          ack,
    input logic [IW-1:0] ack_id,
    input logic          mem_req,
    input logic          mem_we,
    input logic [W-1:0]  mem_addr,
    input logic          pc_ld
);

    localparam logic [IW-1:0] ID_RST = IW'(N_SRC - 1);

    logic [3:0] run_cnt;
    logic       rst_fetch;

    assign rst_fetch = ack && (ack_id == ID_RST);

    // Count busy cycles since the start of a sequence (restart at reset fetch).
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_cnt <= '0;
        end else if (rst_fetch) begin
            run_cnt <= 4'd1;
        end else if (run_cnt != 4'hF) begin
            run_cnt <= run_cnt + 4'd1;
        end
    end

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R2
    vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (mem_req && !mem_we && mem_addr == VEC_BASE + (W'(ack_id) << 1)));

    // R4
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) - W'(2)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !pc_ld && !ack));

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rst_fetch) |-> (run_cnt < 4'd6));

endmodule

bind irq_vector_seq irq_vector_seq_chk #(
    .W        (W),
    .N_SRC    (N_SRC),
    .VEC_BASE (VEC_BASE)
) u_chk (.*);

// File: tb/sim_irq_vector_seq.sv
`timescale 1ns/1ps
module sim_irq_vector_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] irq_lines;
    logic        nmi_req, rst_req, insn_done, ret_req;
    logic [15:0] pc_r, sr_r, sp_r, rdata_r;
    logic        busy, mem_req, mem_we, pc_ld, sr_ld, sp_ld, ack;
    logic [15:0] mem_addr, mem_wdata, pc_nxt, sr_nxt, sp_nxt;
    logic [3:0]  ack_id;

    // core register pokes from the stimulus
    logic        poke_en;
    logic [15:0] poke_pc, poke_sr, poke_sp;

    logic [15:0] stk [0:255];   // words at 0x0200..0x03FF

    int n_chk = 0, n_fail = 0;
    int ack_cnt = 0, wr_cnt = 0;
    logic [3:0] last_id = '0;
    int busy_len;

    // 200 MHz
    always #2.5 clk = ~clk;

    irq_vector_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_req(nmi_req),
        .rst_req(rst_req), .insn_done(insn_done), .ret_req(ret_req),
        .pc_in(pc_r), .sr_in(sr_r), .sp_in(sp_r), .mem_rdata(rdata_r),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_ld(pc_ld), .pc_nxt(pc_nxt), .sr_ld(sr_ld),
        .sr_nxt(sr_nxt), .sp_ld(sp_ld), .sp_nxt(sp_nxt), .ack(ack), .ack_id(ack_id)
    );

    function automatic logic [15:0] vec_word(input int n);
        return 16'hA000 + 16'(n) * 16'h0110;
    endfunction

    function automatic int sidx(input logic [15:0] a);
        return int'((a - 16'h0200) >> 1);
    endfunction

    // core register model
    always @(posedge clk) begin
        if (poke_en) begin
            pc_r <= poke_pc; sr_r <= poke_sr; sp_r <= poke_sp;
        end else begin
            if (pc_ld) pc_r <= pc_nxt;
            if (sr_ld) sr_r <= sr_nxt;
            if (sp_ld) sp_r <= sp_nxt;
        end
    end

    // memory model: vectors computed, stack stored, one-cycle read
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            if (mem_addr >= 16'h0200 && mem_addr < 16'h0400) stk[sidx(mem_addr)] <= mem_wdata;
        end else if (mem_req) begin
            if (mem_addr >= 16'hFFE0) rdata_r <= vec_word(int'((mem_addr - 16'hFFE0) >> 1));
            else if (mem_addr >= 16'h0200 && mem_addr < 16'h0400) rdata_r <= stk[sidx(mem_addr)];
            else rdata_r <= 16'hDEAD;
        end
    end

    // port monitor
    always @(negedge clk) begin
        if (ack) begin ack_cnt++; last_id <= ack_id; end
        if (mem_req && mem_we) wr_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_core(input logic [15:0] pc, input logic [15:0] sr, input logic [15:0] sp);
        poke_pc = pc; poke_sr = sr; poke_sp = sp; poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_idle();
        busy_len = 0;
        while (busy && busy_len < 50) begin busy_len++; @(negedge clk); end
    endtask

    task automatic boundary(input logic ret);
        insn_done = 1'b1; ret_req = ret;
        @(negedge clk);
        insn_done = 1'b0; ret_req = 1'b0;
        wait_idle();
    endtask

    // {irq[13:0], nmi, gie, expected source}
    localparam logic [19:0] TBL [8] = '{
        {14'h0001, 1'b0, 1'b1, 4'd0},
        {14'h0208, 1'b0, 1'b1, 4'd9},
        {14'h3FFF, 1'b0, 1'b1, 4'd13},
        {14'h0020, 1'b1, 1'b1, 4'd14},
        {14'h0000, 1'b1, 1'b0, 4'd14},
        {14'h2002, 1'b0, 1'b1, 4'd13},
        {14'h0080, 1'b0, 1'b1, 4'd7},
        {14'h1004, 1'b0, 1'b1, 4'd12}
    };

    initial begin
        rst_n = 1'b0; irq_lines = '0; nmi_req = 0; rst_req = 0;
        insn_done = 0; ret_req = 0; poke_en = 0;
        poke_pc = '0; poke_sr = '0; poke_sp = 16'h0400;
        repeat (2) @(negedge clk);
        set_core(16'h1000, 16'h0000, 16'h0400);
        @(negedge clk);
        // R11 reset state
        check(!busy && !mem_req && !ack && !pc_ld && !sr_ld && !sp_ld, "R11 reset idle",
              {busy, mem_req, ack, pc_ld}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: entry then return for each vector
        for (int i = 0; i < 8; i++) begin
            logic [15:0] opc, osr;
            int a0, ex;
            ex  = int'(TBL[i][3:0]);
            opc = 16'h1200 + 16'(i * 4);
            osr = 16'h0101 | (TBL[i][4] ? 16'h0008 : 16'h0000);
            set_core(opc, osr, 16'h0400);
            irq_lines = TBL[i][19:6];
            if (TBL[i][5]) begin nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0; end
            a0 = ack_cnt;
            boundary(1'b0);
            check(last_id == 4'(ex), "R1 serviced source", last_id, ex);
            check(ack_cnt - a0 == 1, "R8 one ack", ack_cnt - a0, 1);
            check(busy_len == 6, "R5 entry length", busy_len, 6);
            check(pc_r == vec_word(ex), "R5 R2 vector loaded", pc_r, vec_word(ex));
            check(sr_r == 16'h0 && sp_r == 16'h03FC, "R4 status cleared sp", {sr_r, sp_r}, 32'h000003FC);
            check(stk[sidx(16'h03FE)] == opc && stk[sidx(16'h03FC)] == osr, "R4 frame order",
                  {stk[sidx(16'h03FE)], stk[sidx(16'h03FC)]}, {opc, osr});
            irq_lines = '0;
            boundary(1'b1);
            check(busy_len == 5, "R6 return length", busy_len, 5);
            check(pc_r == opc && sr_r == osr && sp_r == 16'h0400, "R6 context restored",
                  {pc_r, sr_r}, {opc, osr});
        end

        // R3: maskable lines ignored while enable clear
        begin
            int a0;
            set_core(16'h3000, 16'h0101, 16'h0400);
            irq_lines = 14'h3FFF;
            a0 = ack_cnt;
            boundary(1'b0);
            repeat (3) @(negedge clk);
            check(!busy && busy_len == 0 && pc_r == 16'h3000 && ack_cnt == a0, "R3 masked ignored",
                  {pc_r, 16'(busy_len)}, {16'h3000, 16'h0});
            irq_lines = '0;
        end

        // R9: non-maskable edge during a sequence is held
        set_core(16'h2000, 16'h0008, 16'h0400);
        irq_lines = 14'h0010;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0; nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        wait_idle();
        irq_lines = '0;
        check(last_id == 4'd4, "R9 first entry line 4", last_id, 4);
        boundary(1'b0);
        check(last_id == 4'd14 && pc_r == vec_word(14), "R9 held NMI serviced", last_id, 14);
        check(stk[sidx(16'h03FA)] == vec_word(4) && sp_r == 16'h03F8, "R9 nested frame",
              stk[sidx(16'h03FA)], vec_word(4));

        // R10: return and pending interrupt at one boundary
        begin
            int a0;
            set_core(16'h4444, 16'h0008, 16'h03FC);
            irq_lines = 14'h0040;
            a0 = ack_cnt;
            boundary(1'b1);
            check(busy_len == 5 && ack_cnt == a0, "R10 return first", {16'(busy_len), 16'(ack_cnt - a0)}, {16'd5, 16'd0});
            check(pc_r == 16'h2000 && sr_r == 16'h0008 && sp_r == 16'h0400, "R10 restored",
                  pc_r, 16'h2000);
            boundary(1'b0);
            check(last_id == 4'd6 && busy_len == 6, "R10 interrupt after", last_id, 6);
            irq_lines = '0;
        end

        // R7: reset edge aborts an entry
        begin
            int w0;
            set_core(16'h5555, 16'h0008, 16'h0400);
            irq_lines = 14'h0004;
            insn_done = 1'b1;
            @(negedge clk);
            insn_done = 1'b0; rst_req = 1'b1;
            @(negedge clk);
            rst_req = 1'b0;
            w0 = wr_cnt;
            wait_idle();
            irq_lines = '0;
            check(wr_cnt == w0, "R7 no stack write after abort", wr_cnt - w0, 0);
            check(last_id == 4'd15 && pc_r == vec_word(15), "R7 reset vector", pc_r, vec_word(15));
            check(sp_r == 16'h0400 && sr_r == 16'h0, "R7 sp kept sr cleared", {sp_r, sr_r}, 32'h04000000);
        end

        // R1/R7/R9: reset and NMI edges together
        set_core(16'h6000, 16'h0000, 16'h0400);
        rst_req = 1'b1; nmi_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0; nmi_req = 1'b0;
        @(negedge clk);
        wait_idle();
        check(last_id == 4'd15 && busy_len == 2, "R7 reset first, 2 cycles", {12'h0, last_id, 16'(busy_len)}, {16'd15, 16'd2});
        boundary(1'b0);
        check(last_id == 4'd14 && pc_r == vec_word(14), "R1 NMI after reset", last_id, 14);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule